// File: doc/BRIEF.md
# Drain-Source Fault Qualifier with Reset-Pin Decoder

This block sits between the raw drain-source overvoltage comparators of a half-bridge gate driver and its gate control logic. For each of the two switches (index 0 is the high-side, index 1 is the low-side) it watches the comparator only while that switch's gate is commanded on. It turns a comparator hit into a latched short-circuit fault once a programmable qualify window has been met. The window is set by a 6-bit code in 100 ns steps. A mode bit selects how the window is used. In blanking mode the window is a quiet period after turn-on. In debounce mode the window is a minimum time the comparator must stay asserted without a break.

Any latched fault raises a global fault flag and a drive-disable to the gate control. The active-low reset pin of the driver is synchronised and its low time is measured on the 20 MHz system clock. A low period long enough to be a deliberate pulse clears the latched faults when the pin is released. A very long low period raises a sleep request. All inputs are plain level signals, with no handshake.

Top module: `vdsq_top`

## Requirements
- R1: After rst_n is low, both fault bits, fault_any, drive_disable and sleep_req are 0. The qualify code resets to 16 (1.6 µs) and the mode resets to blanking (cfg_blank = 1).
- R2: While cfg_load is high at a clock edge, cfg_code and cfg_blank are captured and used from the next edge on. The qualify window in cycles is Q = code × 2, so each code step is 100 ns at 20 MHz.
- R3: In blanking mode, a switch's fault bit is set at the first edge where its gate has been sampled on for at least Q consecutive edges and its comparator is sampled high. Comparator samples inside the first Q edges of gate-on have no effect.
- R4: In debounce mode, a fault bit is set only after the comparator has been sampled high on Q consecutive gate-on edges and is still high on the next edge. Any low sample restarts the count.
- R5: While a switch's gate is off, its comparator has no effect, and its qualify count restarts at the next turn-on.
- R6: A set fault bit stays set until a clear. fault_any and drive_disable are high exactly while at least one fault bit is set.
- R7: resetn_pin passes through a two-flop synchroniser. A synchronised low lasting fewer than 10 cycles (0.5 µs) neither clears faults nor requests sleep.
- R8: When the synchronised pin returns high after a low lasting at least 10 cycles, a one-cycle clear is produced and all fault bits go to 0 on the following edge. A low lasting up to 600 cycles does this without raising sleep_req.
- R9: sleep_req rises once the synchronised pin has been low for 600 cycles (30 µs). It falls when the synchronised pin returns high, and that release also clears faults.
- R10: Code 0 gives Q = 0: a comparator sample high on the first gate-on edge sets the fault in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| cfg_load | input | 1 | Capture strobe for the qualify settings |
| cfg_code | input | 6 | Qualify time code, 100 ns per step |
| cfg_blank | input | 1 | 1 = blanking mode, 0 = debounce mode |
| gate_on | input | 2 | Gate commanded on; bit 0 high-side, bit 1 low-side |
| vds_hi | input | 2 | Raw drain-source comparator outputs, same bit order |
| resetn_pin | input | 1 | Asynchronous active-low reset pin level |
| fault | output | 2 | Latched short-circuit fault per switch |
| fault_any | output | 1 | Global fault flag |
| drive_disable | output | 1 | Forces the gate control off |
| sleep_req | output | 1 | Low-power sleep request |

## Verification
Some properties hold on every cycle, and the embedded assertions check them there. A fault can only rise on a cycle when the gate was on and the comparator was high. A fault holds until a clear. In debounce mode, a low comparator sample restarts the count. The clear is always a single-cycle pulse and never coincides with the sleep request. The exact cycle on which a fault appears for a given code and mode can only be shown by the bench scenarios, which compare against a behavioural model. The same holds for glitch trains that never qualify, and for the pulse-width boundaries of the reset pin that separate ignore, clear and sleep.

// File: rtl/vdsq_pkg.sv
package vdsq_pkg;
  parameter int QCODE_W = 6;
  parameter logic [QCODE_W-1:0] QCODE_RESET = 6'd16;
  parameter int NUM_SW = 2;
  typedef enum int {SW_HIGH = 0, SW_LOW = 1} sw_idx_e;
  typedef struct packed {
    logic [QCODE_W-1:0] code;
    logic               blank;
  } qual_cfg_t;
endpackage

// File: rtl/vdsq_channel.sv
module vdsq_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic             vds_hi,
  input  logic             blank_mode,
  input  logic [CNT_W-1:0] qual_cyc,
  input  logic             clr,
  output logic             fault
);
  logic [CNT_W-1:0] cnt;
  logic             hit;

  // a hit needs the gate on, the comparator high and the window met
  assign hit = gate_on && vds_hi && (cnt >= qual_cyc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      if (!gate_on)
        cnt <= '0;
      else if (!blank_mode && !vds_hi)
        cnt <= '0;
      else if (cnt < qual_cyc)
        cnt <= cnt + 1'b1;

      if (hit)
        fault <= 1'b1;
      else if (clr)
        fault <= 1'b0;
    end
  end

  // R5: a fault only rises after a gate-on comparator sample
  p_rise_needs_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(gate_on && vds_hi));
  // R6: latched until a clear
  p_hold_until_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault);
  // R4: debounce restarts on a low sample
  p_debounce_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !blank_mode && !vds_hi) |=> (cnt == '0));
endmodule

// File: rtl/vdsq_rst_decode.sv
module vdsq_rst_decode #(
  parameter int MIN_CYC   = 10,
  parameter int SLEEP_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic clr,
  output logic sleep_req
);
  localparam int LO_W = $clog2(SLEEP_CYC + 1);

  logic            sync1, sync2;
  logic [LO_W-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1     <= 1'b1;
      sync2     <= 1'b1;
      lo_cnt    <= '0;
      clr       <= 1'b0;
      sleep_req <= 1'b0;
    end else begin
      sync1 <= pin_n;
      sync2 <= sync1;
      if (!sync2) begin
        if (lo_cnt < LO_W'(SLEEP_CYC))
          lo_cnt <= lo_cnt + 1'b1;
      end else begin
        lo_cnt <= '0;
      end
      clr       <= sync2 && (lo_cnt >= LO_W'(MIN_CYC));
      sleep_req <= !sync2 && (lo_cnt >= LO_W'(SLEEP_CYC));
    end
  end

  // R8: the clear is a single-cycle pulse
  p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !clr);
  // R9: sleep and clear never coincide
  p_sleep_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && sleep_req));
  // R9: sleep rises only after the full low time
  p_sleep_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_req) |-> $past(lo_cnt >= LO_W'(SLEEP_CYC)));
endmodule

// File: rtl/vdsq_top.sv
module vdsq_top
  import vdsq_pkg::*;
#(
  parameter int CLK_PER_STEP  = 2,
  parameter int RST_MIN_CYC   = 10,
  parameter int RST_SLEEP_CYC = 600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [QCODE_W-1:0] cfg_code,
  input  logic               cfg_blank,
  input  logic [NUM_SW-1:0]  gate_on,
  input  logic [NUM_SW-1:0]  vds_hi,
  input  logic               resetn_pin,
  output logic [NUM_SW-1:0]  fault,
  output logic               fault_any,
  output logic               drive_disable,
  output logic               sleep_req
);
  localparam int CNT_W = QCODE_W + $clog2(CLK_PER_STEP) + 1;

  qual_cfg_t        cfg_q;
  logic [CNT_W-1:0] qual_cyc;
  logic             clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.code  <= QCODE_RESET;
      cfg_q.blank <= 1'b1;
    end else if (cfg_load) begin
      cfg_q.code  <= cfg_code;
      cfg_q.blank <= cfg_blank;
    end
  end

  assign qual_cyc = CNT_W'(cfg_q.code) * CNT_W'(CLK_PER_STEP);

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    vdsq_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_on    (gate_on[i]),
      .vds_hi     (vds_hi[i]),
      .blank_mode (cfg_q.blank),
      .qual_cyc   (qual_cyc),
      .clr        (clr),
      .fault      (fault[i])
    );
  end

  vdsq_rst_decode #(.MIN_CYC(RST_MIN_CYC), .SLEEP_CYC(RST_SLEEP_CYC)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_n     (resetn_pin),
    .clr       (clr),
    .sleep_req (sleep_req)
  );

  assign fault_any     = |fault;
  assign drive_disable = fault_any;

  // R6: any latched fault keeps the flag up until a clear
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !clr) |=> fault_any);
endmodule

// File: tb/sim_vdsq_top.sv
module sim_vdsq_top;
  localparam int CLK_NS = 50;
  localparam int MINC = 10;
  localparam int SLPC = 600;

  logic clk = 0, rst_n = 0, cfg_load = 0, cfg_blank = 1, resetn_pin = 1;
  logic [5:0] cfg_code = 0;
  logic [1:0] gate_on = 0, vds_hi = 0, fault;
  logic fault_any, drive_disable, sleep_req;

  int total = 0, bad = 0;
  string cur_req = "R1";

  vdsq_top u0 (.clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .cfg_blank(cfg_blank), .gate_on(gate_on), .vds_hi(vds_hi), .resetn_pin(resetn_pin),
    .fault(fault), .fault_any(fault_any), .drive_disable(drive_disable), .sleep_req(sleep_req));

  always #(CLK_NS/2) clk = ~clk;

  // behavioural reference
  int m_code = 16, m_blank = 1, m_lo = 0;
  int m_cnt[2];
  bit m_fault[2];
  bit m_s1 = 1, m_s2 = 1, m_clr = 0, m_sleep = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 16; m_blank = 1; m_lo = 0; m_s1 = 1; m_s2 = 1; m_clr = 0; m_sleep = 0;
      for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_fault[i] = 0; end
    end else begin
      int q;
      bit n_clr, n_sleep;
      q = m_code * 2;
      for (int i = 0; i < 2; i++) begin
        bit hit;
        hit = gate_on[i] && vds_hi[i] && (m_cnt[i] >= q);
        if (hit) m_fault[i] = 1; else if (m_clr) m_fault[i] = 0;
        if (!gate_on[i]) m_cnt[i] = 0;
        else if (m_blank == 0 && !vds_hi[i]) m_cnt[i] = 0;
        else if (m_cnt[i] < q) m_cnt[i]++;
      end
      n_clr = m_s2 && (m_lo >= MINC);
      n_sleep = !m_s2 && (m_lo >= SLPC);
      if (!m_s2) begin if (m_lo < SLPC) m_lo++; end else m_lo = 0;
      m_clr = n_clr; m_sleep = n_sleep;
      m_s2 = m_s1; m_s1 = resetn_pin;
      if (cfg_load) begin m_code = cfg_code; m_blank = cfg_blank; end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    check(fault == {m_fault[1], m_fault[0]}, cur_req, "fault", fault, {m_fault[1], m_fault[0]});
    check(fault_any == (m_fault[0] | m_fault[1]), "R6", "fault_any", fault_any, m_fault[0] | m_fault[1]);
    check(drive_disable == (m_fault[0] | m_fault[1]), "R6", "drive_disable", drive_disable, m_fault[0] | m_fault[1]);
    check(sleep_req == m_sleep, cur_req, "sleep_req", sleep_req, m_sleep);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int code, input bit blank);
    cfg_code = 6'(code); cfg_blank = blank; cfg_load = 1; cyc(1); cfg_load = 0;
  endtask

  task automatic pin_low(input int n);
    resetn_pin = 0; cyc(n); resetn_pin = 1; cyc(4);
  endtask

  initial begin : watchdog
    #(CLK_NS * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    check(fault == 2'b00 && !sleep_req && !drive_disable, "R1", "reset outputs", {fault, sleep_req}, 0);

    // R3 blanking with default code 16 -> 32 cycles
    cur_req = "R3";
    gate_on[0] = 1; vds_hi[0] = 1; cyc(31);
    check(fault[0] == 0, "R3", "inside blank window", fault[0], 0);
    cyc(2);
    check(fault[0] == 1, "R3", "after blank window", fault[0], 1);
    gate_on[0] = 0; vds_hi[0] = 0; cyc(2);
    check(fault_any == 1, "R6", "flag held with gate off", fault_any, 1);

    // R7 short pulse ignored
    cur_req = "R7";
    pin_low(MINC - 1);
    check(fault[0] == 1, "R7", "short pulse ignored", fault[0], 1);

    // R8 clear pulse
    cur_req = "R8";
    pin_low(MINC + 5);
    check(fault == 0 && !sleep_req, "R8", "cleared by pulse", fault, 0);

    // R2 + R4 debounce with code 3 -> 6 cycles
    cur_req = "R4";
    load(3, 0); gate_on[1] = 1;
    for (int k = 0; k < 3; k++) begin vds_hi[1] = 1; cyc(6); vds_hi[1] = 0; cyc(1); end
    check(fault[1] == 0, "R4", "glitches do not qualify", fault[1], 0);
    vds_hi[1] = 1; cyc(8);
    check(fault[1] == 1, "R4", "sustained qualifies", fault[1], 1);
    check(drive_disable == 1, "R6", "disable set", drive_disable, 1);
    vds_hi[1] = 0; gate_on[1] = 0;
    pin_low(100);
    check(fault == 0 && !sleep_req, "R8", "mid-length low clears only", {fault, sleep_req}, 0);

    // R5 gate off ignores comparator
    cur_req = "R5";
    vds_hi = 2'b11; cyc(80);
    check(fault == 0, "R5", "gate off", fault, 0);
    gate_on[0] = 1; cyc(5); vds_hi[0] = 0; cyc(1); gate_on[0] = 0; cyc(2);
    check(fault[0] == 0, "R5", "restart after off", fault[0], 0);
    vds_hi = 0;

    // R10 code 0 in blanking mode
    cur_req = "R10";
    load(0, 1); vds_hi[1] = 1; gate_on[1] = 1; cyc(2);
    check(fault[1] == 1, "R10", "code 0 immediate", fault[1], 1);
    gate_on[1] = 0; vds_hi[1] = 0;

    // R2 longer code in blanking, R3 again
    cur_req = "R2";
    load(5, 1); pin_low(20);
    gate_on[0] = 1; vds_hi[0] = 1; cyc(9);
    check(fault[0] == 0, "R2", "window 10 cycles not met", fault[0], 0);
    cyc(3);
    check(fault[0] == 1, "R2", "window 10 cycles met", fault[0], 1);
    gate_on[0] = 0; vds_hi[0] = 0;

    // R9 sleep request
    cur_req = "R9";
    resetn_pin = 0; cyc(SLPC);
    check(sleep_req == 0, "R9", "sleep not yet", sleep_req, 0);
    cyc(5);
    check(sleep_req == 1, "R9", "sleep raised", sleep_req, 1);
    resetn_pin = 1; cyc(5);
    check(sleep_req == 0 && fault == 0, "R9", "release drops sleep and clears", {fault, sleep_req}, 0);

    cyc(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule